// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit up-counting timer with a four-register interface on a small offset window. It divides the system clock by a programmable 8-bit prescaler and advances the counter once per prescaled tick. When the count equals a programmed reference value on a tick, the block sets a sticky event flag. Depending on a mode bit, the counter then either restarts from zero or carries on upward and wraps at 0xFFFF.

An interrupt line is the AND of an enable bit in the mode register and the sticky event flag. Software clears the flag by writing a 1 to it. Clearing the enable bit of a running timer also acts as a soft reset of the timer's state. Registers are written with a single-cycle write strobe. Reads are combinational from the offset.

Register offsets: 0 mode, 1 reference, 2 counter, 3 event. Mode fields: bit 0 enable, bits 2:1 clock source, bit 3 restart-on-match, bit 4 interrupt enable, bits 15:8 prescale minus one. Event field: bit 1 reference-match flag.

Top module: `refcmp_timer`

## Requirements
- R1: After reset the mode and counter registers read 0, the reference register reads 0xFFFF, the event register reads 0 and `irq_o` is low.
- R2: While mode bit 0 is 0, the counter holds its value and only changes through a counter-register write.
- R3: With the timer running, the counter advances by one every (mode[15:8] + 1) clock cycles. The first advance comes that many cycles after the enabling write.
- R4: With clock-source field mode[2:1] equal to 0 or 3, the counter does not advance even when mode bit 0 is 1. Values 1 and 2 both run from the system clock.
- R5: With mode bit 3 set, a tick that finds the counter equal to the reference returns the counter to 0.
- R6: With mode bit 3 clear, the counter keeps counting past the reference and steps from 0xFFFF to 0.
- R7: `irq_o` is high exactly when mode bit 4 is 1 and the event flag is 1.
- R8: The event flag (event register bit 1) becomes 1 on the clock edge of a tick that finds the counter equal to the reference, whatever the restart bit holds.
- R9: Writing the event register with bit 1 set clears the flag. Writing it with bit 1 clear leaves the flag unchanged.
- R10: A mode write that changes bit 0 from 1 to 0 clears the counter, the prescaler and the event flag, returns the reference to 0xFFFF, and stores the written mode value.
- R11: A counter-register write loads the counter on that edge, taking priority over a tick. A counter read returns the current count.
- R12: Offset 0 reads the mode, 1 the reference, 2 the count and 3 the event register. In the event register only bit 1 is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | ADDR_W (2) | Register offset |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A wrong prescaler phase shows up at the counter offset within one prescale period. It appears as a count that is one ahead or one behind the arithmetic value floor(cycles / divisor). A compare or restart fault appears on the tick after the count reaches the reference: either the count fails to return to zero, or the event flag and `irq_o` miss that edge. Stale state after a soft reset is visible on the very next read of the reference, counter or event offsets.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
  // mode register field positions
  localparam int unsigned MODE_EN     = 0;
  localparam int unsigned MODE_SRC_LO = 1;
  localparam int unsigned MODE_RR     = 3;
  localparam int unsigned MODE_IE     = 4;
  localparam int unsigned MODE_PRE_LO = 8;
  // event register field position
  localparam int unsigned EVT_REF     = 1;

  typedef enum logic [1:0] {
    OFS_MODE = 2'd0,
    OFS_REF  = 2'd1,
    OFS_CNT  = 2'd2,
    OFS_EVT  = 2'd3
  } reg_ofs_e;

  // only the two internal clock paths are supported
  function automatic logic src_supported(input logic [1:0] src);
    return (src == 2'd1) || (src == 2'd2);
  endfunction
endpackage

// File: rtl/refcmp_prescaler.sv
module refcmp_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q;

  // ">=" keeps a shrinking divisor from stalling the phase counter
  assign tick = run && (pcnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pcnt_q <= '0;
    else if (clr || !run || tick) pcnt_q <= '0;
    else                          pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] count,
  output logic             match_tick
);
  function automatic logic [CNT_W-1:0] advance(
    input logic [CNT_W-1:0] cur,
    input logic             hit,
    input logic             rr
  );
    if (hit && rr) return '0;
    return cur + 1'b1;  // natural wrap at all-ones
  endfunction

  assign match_tick = tick && (count == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= advance(count, match_tick, restart);
  end
endmodule

// File: rtl/refcmp_event.sv
module refcmp_event (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic wr_clear,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  // a match on the same edge as a software clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (clr)      flag <= 1'b0;
    else if (set)      flag <= 1'b1;
    else if (wr_clear) flag <= 1'b0;
  end

  assign irq = irq_en && flag;
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import refcmp_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_REF  = ADDR_W'(OFS_REF);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVT);

  logic [CNT_W-1:0] mode_q, ref_q, count_q;
  logic             evt_q;

  // named internal events
  logic wr_mode_w, wr_ref_w, wr_cnt_w, wr_evt_w;
  logic soft_clr_w, run_w, tick_w, match_tick_w, evt_wclr_w;

  assign wr_mode_w  = bus_wr && (bus_addr == A_MODE);
  assign wr_ref_w   = bus_wr && (bus_addr == A_REF);
  assign wr_cnt_w   = bus_wr && (bus_addr == A_CNT);
  assign wr_evt_w   = bus_wr && (bus_addr == A_EVT);
  assign soft_clr_w = wr_mode_w && mode_q[MODE_EN] && !bus_wdata[MODE_EN];
  assign run_w      = mode_q[MODE_EN] && src_supported(mode_q[MODE_SRC_LO +: 2]);
  assign evt_wclr_w = wr_evt_w && bus_wdata[EVT_REF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= '0;
    else if (wr_mode_w) mode_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ref_q <= '1;
    else if (soft_clr_w) ref_q <= '1;
    else if (wr_ref_w)   ref_q <= bus_wdata;
  end

  refcmp_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_clr_w),
    .run   (run_w),
    .limit (mode_q[MODE_PRE_LO +: PRE_W]),
    .tick  (tick_w)
  );

  refcmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_clr_w),
    .load       (wr_cnt_w),
    .load_val   (bus_wdata),
    .tick       (tick_w),
    .restart    (mode_q[MODE_RR]),
    .ref_val    (ref_q),
    .count      (count_q),
    .match_tick (match_tick_w)
  );

  refcmp_event u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_clr_w),
    .set      (match_tick_w),
    .wr_clear (evt_wclr_w),
    .irq_en   (mode_q[MODE_IE]),
    .flag     (evt_q),
    .irq      (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MODE)     bus_rdata = mode_q;
    else if (bus_addr == A_REF) bus_rdata = ref_q;
    else if (bus_addr == A_CNT) bus_rdata = count_q;
    else if (bus_addr == A_EVT) bus_rdata[EVT_REF] = evt_q;
  end
endmodule

// File: rtl/refcmp_timer_chk.sv
module refcmp_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] mode_q,
  input logic [CNT_W-1:0] ref_q,
  input logic [CNT_W-1:0] count_q,
  input logic             evt_q,
  input logic             tick_w,
  input logic             match_tick_w,
  input logic             soft_clr_w,
  input logic             wr_cnt_w,
  input logic             irq_o
);
  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[0] && !wr_cnt_w) |=> $stable(count_q));

  // R4
  src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |-> (mode_q[0] && (mode_q[2:1] == 2'd1 || mode_q[2:1] == 2'd2)));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_tick_w && mode_q[3] && !wr_cnt_w && !soft_clr_w) |=> (count_q == '0));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && (count_q == '1) && !wr_cnt_w && !soft_clr_w) |=> (count_q == '0));

  // R7
  irq_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (mode_q[4] && evt_q));

  // R8
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_tick_w && !soft_clr_w) |=> evt_q);

  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr_w |=> (count_q == '0 && !evt_q && ref_q == '1 && !mode_q[0]));
endmodule

bind refcmp_timer refcmp_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_q       (mode_q),
  .ref_q        (ref_q),
  .count_q      (count_q),
  .evt_q        (evt_q),
  .tick_w       (tick_w),
  .match_tick_w (match_tick_w),
  .soft_clr_w   (soft_clr_w),
  .wr_cnt_w     (wr_cnt_w),
  .irq_o        (irq_o)
);

// File: tb/refcmp_timer_tb_top.sv
module refcmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int vectors = 0;
  int errors  = 0;

  localparam logic [1:0] M = 2'd0, RF = 2'd1, CT = 2'd2, EV = 2'd3;

  always #5 clk = ~clk;

  refcmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 / R12 reset values per offset
    rd(M, v);  chk("R1 mode", v, 16'h0000);
    rd(RF, v); chk("R1 ref", v, 16'hFFFF);
    rd(CT, v); chk("R1 count", v, 16'h0000);
    rd(EV, v); chk("R1 event", v, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);

    // R11 load while stopped, R2 hold while disabled
    wr(CT, 16'h1234);
    rd(CT, v); chk("R11 load", v, 16'h1234);
    idle(10);
    rd(CT, v); chk("R2 hold", v, 16'h1234);
    wr(CT, 16'h0000);

    // R4 unsupported clock sources
    wr(M, 16'h0001);  // enable, src 0
    idle(10);
    rd(CT, v); chk("R4 src0", v, 16'h0000);
    wr(M, 16'h0007);  // enable, src 3
    idle(10);
    rd(CT, v); chk("R4 src3", v, 16'h0000);
    wr(M, 16'h0000);

    // R3 R5 R8 R7: sweep of prescale x reference, restart on, irq enabled
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        int pre, rf, dv, tk, span;
        pre = (i == 3) ? 5 : i;
        rf  = (j == 3) ? 4 : j;
        dv  = pre + 1;
        span = dv * (rf + 2) + 1;
        wr(M, 16'h0000);
        wr(RF, 16'(rf));
        wr(M, {8'(pre), 8'h1B});  // ie, restart, src 1, enable
        for (int t = 1; t <= span; t++) begin
          @(negedge clk);
          tk = t / dv;
          rd(CT, v); chk("R3 R5 count", v, 16'(tk % (rf + 1)));
          rd(EV, v); chk("R8 event", v, (tk >= rf + 1) ? 16'h0002 : 16'h0000);
          chk("R7 irq", {15'd0, irq_o}, (tk >= rf + 1) ? 16'd1 : 16'd0);
        end
      end
    end
    wr(M, 16'h0000);

    // R6 wrap and R8 match without restart
    wr(CT, 16'hFFFE);
    wr(RF, 16'h0005);
    wr(M, 16'h0003);  // div 1, src 1, enable, no restart, no ie
    idle(1); rd(CT, v); chk("R6 at ffff", v, 16'hFFFF);
    idle(1); rd(CT, v); chk("R6 wrap", v, 16'h0000);
    idle(5); rd(CT, v); chk("R6 count5", v, 16'h0005);
    rd(EV, v); chk("R8 before match", v, 16'h0000);
    idle(1); rd(CT, v); chk("R6 past ref", v, 16'h0006);
    rd(EV, v); chk("R8 no-restart match", v, 16'h0002);
    chk("R7 irq masked", {15'd0, irq_o}, 16'd0);

    // R7 enable irq without soft reset
    wr(M, 16'h0013);
    chk("R7 irq on", {15'd0, irq_o}, 16'd1);

    // R9 event clear semantics
    wr(EV, 16'hFFFD);
    rd(EV, v); chk("R9 write0 keeps", v, 16'h0002);
    wr(EV, 16'h0002);
    rd(EV, v); chk("R9 write1 clears", v, 16'h0000);
    chk("R9 irq drops", {15'd0, irq_o}, 16'd0);

    // R11 load while running takes effect, then R8 match from loaded value
    wr(CT, 16'h0004);
    rd(CT, v); chk("R11 run load", v, 16'h0004);
    idle(1); rd(CT, v); chk("R11 resume", v, 16'h0005);
    idle(1); rd(EV, v); chk("R8 rematch", v, 16'h0002);

    // R10 soft reset
    wr(M, 16'h0510);
    rd(M, v);  chk("R10 mode stored", v, 16'h0510);
    rd(RF, v); chk("R10 ref", v, 16'hFFFF);
    rd(CT, v); chk("R10 count", v, 16'h0000);
    rd(EV, v); chk("R10 event", v, 16'h0000);
    chk("R10 irq", {15'd0, irq_o}, 16'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule